// File: doc/BRIEF.md
# Bidirectional link direction controller

This block decides, for one shared bidirectional channel between two routers, whether the local router may drive the channel outward. It is used once per link end. One end is strapped to priority behaviour and the other to normal behaviour. Each end talks to the other through a single request wire. The two ends run on unrelated clocks. The incoming request therefore passes through a local two-flop synchronizer before the state machine looks at it.

Each end runs a three-state machine with the states initial, free and delay. The priority end owns the channel by default. It yields the channel only when it has nothing to send and the neighbour asks for it. When it wants the channel back, it raises its request for a fixed guard window before it drives again. The normal end claims the channel only when the priority end is silent. It then waits out a longer guard window, and it drops back at once whenever the priority end raises its request. Both outputs are registered. The mode input is static and is changed only while reset is held.

Top module: `link_dir_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `chan_req_o` and `out_en_o` become 0. A priority end leaves reset in free and a normal end leaves reset in initial.
- R2: The neighbour request is sampled by a two-stage synchronizer that clears on reset. A change on `nbr_req_i` first influences the state machine at the third rising edge after it is applied.
- R3: A priority end in free stays in free while `dir_req_i` is 1 or the synchronized neighbour request is 0. In free, `chan_req_o` and `out_en_o` both equal `dir_req_i` as sampled at the preceding edge.
- R4: A priority end in free moves to initial when `dir_req_i` is 0 and the synchronized neighbour request is 1. Initial drives both outputs to 0, clears the counter, and holds while `dir_req_i` is 0.
- R5: A priority end in initial enters delay when `dir_req_i` is 1. Delay lasts exactly PRIO_HOLD (default 4) clock cycles, whatever the inputs do, with `chan_req_o`=1 and `out_en_o`=0. It then enters free.
- R6: A normal end in initial drives both outputs to 0. It leaves initial for delay only when `dir_req_i` is 1 and the synchronized neighbour request is 0.
- R7: A normal end in delay drives `chan_req_o`=1 and `out_en_o`=0. It enters free after NORM_HOLD (default 8) consecutive cycles with the neighbour request at 0. If the neighbour request is 1 in any of those cycles, it returns to initial, and a later entry to delay restarts the full count.
- R8: A normal end in free drives `chan_req_o`=1 and `out_en_o`=1 regardless of `dir_req_i`. It returns to initial at the first edge at which the synchronized neighbour request is 1.
- R9: `out_en_o` is 1 only in free. Whenever it is 1, `chan_req_o` is 1 too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_mode_i | input | 1 | 1 = priority end, 0 = normal end; static outside reset |
| dir_req_i | input | 1 | Local flits are waiting to leave on this link |
| nbr_req_i | input | 1 | Raw channel request from the neighbour (other clock domain) |
| chan_req_o | output | 1 | Registered channel request to the neighbour |
| out_en_o | output | 1 | Registered permission to drive flits outward |

## Verification
The bench uses the default guard windows of 4 and 8 cycles and two synchronizer stages. With these values, a full normal-mode guard window, an abort inside it and a restart from zero all fit in a few dozen cycles. The exact edge at which a delay ends can then be pinned down on both sides. The fixed two-stage latency lets the bench place each neighbour request change on a known edge. It can then show that the machine reacts on the third edge and not earlier.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_FREE  = 2'd1,
        ST_DELAY = 2'd2
    } ldc_state_e;

    typedef struct packed {
        logic req;
        logic en;
    } ldc_out_t;

    function automatic ldc_state_e reset_state(input logic prio);
        return prio ? ST_FREE : ST_INIT;
    endfunction

    function automatic ldc_out_t out_for(input ldc_state_e st, input logic prio,
                                         input logic dir);
        ldc_out_t o;
        case (st)
            ST_FREE:  begin o.req = prio ? dir : 1'b1; o.en = prio ? dir : 1'b1; end
            ST_DELAY: begin o.req = 1'b1; o.en = 1'b0; end
            default:  begin o.req = 1'b0; o.en = 1'b0; end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/ldc_sync.sv
module ldc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) shift_q <= '0;
                else     shift_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) shift_q <= '0;
                else     shift_q <= {shift_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/ldc_fsm.sv
module ldc_fsm
    import ldc_pkg::*;
#(
    parameter int PRIO_HOLD = 4,
    parameter int NORM_HOLD = 8,
    parameter int CW        = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prio_i,
    input  logic       dir_i,
    input  logic       nbr_i,
    output ldc_state_e state_o,
    output logic [CW-1:0] cnt_o,
    output ldc_out_t   nxt_out_o
);
    localparam logic [CW-1:0] PRIO_LAST = CW'(PRIO_HOLD - 1);
    localparam logic [CW-1:0] NORM_LAST = CW'(NORM_HOLD - 1);

    ldc_state_e state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        case (state_q)
            ST_FREE: begin
                if (prio_i) begin
                    if (!dir_i && nbr_i) state_n = ST_INIT;
                end else if (nbr_i) begin
                    state_n = ST_INIT;
                end
                cnt_n = '0;
            end
            ST_INIT: begin
                cnt_n = '0;
                if (prio_i) begin
                    if (dir_i) state_n = ST_DELAY;
                end else if (dir_i && !nbr_i) begin
                    state_n = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (prio_i) begin
                    if (cnt_q == PRIO_LAST) begin
                        state_n = ST_FREE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end else if (nbr_i) begin
                    state_n = ST_INIT;
                    cnt_n   = '0;
                end else if (cnt_q == NORM_LAST) begin
                    state_n = ST_FREE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                state_n = reset_state(prio_i);
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= reset_state(prio_i);
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign state_o   = state_q;
    assign cnt_o     = cnt_q;
    assign nxt_out_o = rst ? ldc_out_t'(2'b00) : out_for(state_n, prio_i, dir_i);
endmodule

// File: rtl/ldc_outreg.sv
module ldc_outreg
    import ldc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ldc_out_t d_i,
    output ldc_out_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
    end
endmodule

// File: rtl/link_dir_ctrl.sv
module link_dir_ctrl
    import ldc_pkg::*;
#(
    parameter int PRIO_HOLD   = 4,
    parameter int NORM_HOLD   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic prio_mode_i,
    input  logic dir_req_i,
    input  logic nbr_req_i,
    output logic chan_req_o,
    output logic out_en_o
);
    localparam int HOLD_MAX = (PRIO_HOLD > NORM_HOLD) ? PRIO_HOLD : NORM_HOLD;
    localparam int CW       = $clog2(HOLD_MAX + 1);

    logic          nbr_s;
    ldc_state_e    state_w;
    logic [CW-1:0] cnt_w;
    ldc_out_t      nxt_w, out_q;

    ldc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (nbr_req_i),
        .q_o (nbr_s)
    );

    ldc_fsm #(.PRIO_HOLD(PRIO_HOLD), .NORM_HOLD(NORM_HOLD), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .prio_i    (prio_mode_i),
        .dir_i     (dir_req_i),
        .nbr_i     (nbr_s),
        .state_o   (state_w),
        .cnt_o     (cnt_w),
        .nxt_out_o (nxt_w)
    );

    ldc_outreg u_out (
        .clk (clk),
        .rst (rst),
        .d_i (nxt_w),
        .q_o (out_q)
    );

    assign chan_req_o = out_q.req;
    assign out_en_o   = out_q.en;
endmodule

// File: rtl/ldc_checker.sv
module ldc_checker
    import ldc_pkg::*;
#(
    parameter int PRIO_HOLD = 4,
    parameter int NORM_HOLD = 8,
    parameter int CW        = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          prio_mode_i,
    input logic          dir_req_i,
    input logic          chan_req_o,
    input logic          out_en_o,
    input logic          nbr_s,
    input ldc_state_e    state_w,
    input logic [CW-1:0] cnt_w
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!chan_req_o && !out_en_o));

    assert_prio_free_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (prio_mode_i && state_w == ST_FREE && (dir_req_i || !nbr_s)) |=> state_w == ST_FREE);

    assert_prio_yield_R4: assert property (@(posedge clk) disable iff (rst)
        (prio_mode_i && state_w == ST_FREE && !dir_req_i && nbr_s) |=> (state_w == ST_INIT && !chan_req_o));

    assert_prio_window_R5: assert property (@(posedge clk) disable iff (rst)
        (prio_mode_i && state_w == ST_DELAY) |-> (int'(cnt_w) < PRIO_HOLD));

    assert_norm_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (!prio_mode_i && state_w == ST_INIT && !(dir_req_i && !nbr_s)) |=> state_w == ST_INIT);

    assert_norm_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (!prio_mode_i && state_w == ST_DELAY && nbr_s) |=> (state_w == ST_INIT && !chan_req_o));

    assert_norm_window_R7: assert property (@(posedge clk) disable iff (rst)
        (!prio_mode_i && state_w == ST_DELAY) |-> (int'(cnt_w) < NORM_HOLD));

    assert_norm_free_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (!prio_mode_i && state_w == ST_FREE && nbr_s) |=> (state_w == ST_INIT && !out_en_o));

    assert_en_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
        out_en_o |-> chan_req_o);
endmodule

bind link_dir_ctrl ldc_checker #(
    .PRIO_HOLD (PRIO_HOLD),
    .NORM_HOLD (NORM_HOLD),
    .CW        (CW)
) u_ldc_chk (
    .clk         (clk),
    .rst         (rst),
    .prio_mode_i (prio_mode_i),
    .dir_req_i   (dir_req_i),
    .chan_req_o  (chan_req_o),
    .out_en_o    (out_en_o),
    .nbr_s       (nbr_s),
    .state_w     (state_w),
    .cnt_w       (cnt_w)
);

// File: tb/link_dir_ctrl_bench.sv
module link_dir_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prio_mode_i = 1'b1;
    logic dir_req_i = 1'b0;
    logic nbr_req_i = 1'b0;
    logic chan_req_o, out_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_dir_ctrl u_link_dir_ctrl (
        .clk         (clk),
        .rst         (rst),
        .prio_mode_i (prio_mode_i),
        .dir_req_i   (dir_req_i),
        .nbr_req_i   (nbr_req_i),
        .chan_req_o  (chan_req_o),
        .out_en_o    (out_en_o)
    );

    // {reset_first, prio, dir, nbr, edges[3:0], exp_req, exp_en, req_tag[3:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        // priority end
        {1'b1,1'b1,1'b1,1'b0,4'd1,1'b1,1'b1,4'd1}, // R1: leaves reset in free
        {1'b0,1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,4'd3}, // R3: free follows dir
        {1'b0,1'b1,1'b0,1'b1,4'd3,1'b0,1'b0,4'd4}, // R4: yield to neighbour
        {1'b0,1'b1,1'b1,1'b1,4'd1,1'b1,1'b0,4'd5}, // R5: initial -> delay
        {1'b0,1'b1,1'b1,1'b1,4'd3,1'b1,1'b0,4'd5}, // R5: still in window
        {1'b0,1'b1,1'b1,1'b1,4'd1,1'b1,1'b1,4'd5}, // R5: free after 4
        {1'b0,1'b1,1'b1,1'b1,4'd4,1'b1,1'b1,4'd3}, // R3: holds while dir=1
        {1'b0,1'b1,1'b0,1'b1,4'd1,1'b0,1'b0,4'd4}, // R4: yields at once
        {1'b0,1'b1,1'b1,1'b0,4'd1,1'b1,1'b0,4'd4}, // R4: was in initial
        {1'b0,1'b1,1'b1,1'b0,4'd4,1'b1,1'b1,4'd5}, // R5
        // normal end
        {1'b1,1'b0,1'b0,1'b0,4'd3,1'b0,1'b0,4'd1}, // R1: leaves reset in initial
        {1'b0,1'b0,1'b0,1'b1,4'd3,1'b0,1'b0,4'd6}, // R6
        {1'b0,1'b0,1'b1,1'b1,4'd3,1'b0,1'b0,4'd6}, // R6: blocked by neighbour
        {1'b0,1'b0,1'b1,1'b0,4'd2,1'b0,1'b0,4'd2}, // R2: sync latency
        {1'b0,1'b0,1'b1,1'b0,4'd1,1'b1,1'b0,4'd2}, // R2: third edge
        {1'b0,1'b0,1'b1,1'b0,4'd7,1'b1,1'b0,4'd7}, // R7: in window
        {1'b0,1'b0,1'b1,1'b0,4'd1,1'b1,1'b1,4'd7}, // R7: free after 8
        {1'b0,1'b0,1'b0,1'b0,4'd3,1'b1,1'b1,4'd8}, // R8: dir ignored
        {1'b0,1'b0,1'b0,1'b1,4'd2,1'b1,1'b1,4'd2}, // R2
        {1'b0,1'b0,1'b0,1'b1,4'd1,1'b0,1'b0,4'd8}, // R8: back to initial
        {1'b0,1'b0,1'b1,1'b0,4'd3,1'b1,1'b0,4'd6}, // R6
        {1'b0,1'b0,1'b1,1'b1,4'd2,1'b1,1'b0,4'd7}, // R7
        {1'b0,1'b0,1'b1,1'b1,4'd1,1'b0,1'b0,4'd7}, // R7: abort
        {1'b0,1'b0,1'b1,1'b0,4'd3,1'b1,1'b0,4'd7}, // R7: re-entry
        {1'b0,1'b0,1'b1,1'b0,4'd7,1'b1,1'b0,4'd7}, // R7: full count again
        {1'b0,1'b0,1'b1,1'b0,4'd1,1'b1,1'b1,4'd9}  // R9
    };

    task automatic check(input logic req, input logic en, input int tag);
        n_checks++;
        if (chan_req_o !== req || out_en_o !== en) begin
            n_fail++;
            $display("FAIL R%0d: req/en = %b%b, expected %b%b", tag, chan_req_o, out_en_o, req, en);
        end
    endtask

    task automatic do_reset(input logic prio);
        @(negedge clk);
        rst = 1'b1; prio_mode_i = prio; dir_req_i = 1'b0; nbr_req_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, 1'b0, 1); // R1 outputs quiet in reset
        rst = 1'b0;
    endtask

    task automatic step(input logic d, input logic n, input int edges);
        dir_req_i = d; nbr_req_i = n;
        repeat (edges) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][13]) do_reset(VEC[i][12]);
            step(VEC[i][11], VEC[i][10], int'(VEC[i][9:6]));
            check(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
        end
        // R1: reset from normal free returns to initial
        step(1'b1, 1'b0, 1);
        do_reset(1'b0);
        step(1'b1, 1'b0, 1);
        check(1'b1, 1'b0, 1);
        // R5: priority delay ignores dir dropping and neighbour
        do_reset(1'b1);
        step(1'b0, 1'b1, 3);
        step(1'b1, 1'b1, 1);
        step(1'b0, 1'b1, 3);
        check(1'b1, 1'b0, 5);
        step(1'b0, 1'b1, 1);
        check(1'b0, 1'b0, 5); // free with dir=0 then yields
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule